// File: doc/BRIEF.md
# Cache Maintenance Range Splitter

This block sits between a requester that asks for cache maintenance over an arbitrary byte range and a maintenance engine that only accepts line-aligned commands. Each request gives a start byte address, an end byte address that is one past the last byte, and one of three operations: invalidate, clean, or flush (clean then invalidate). The block turns that request into a series of engine commands. A command is either a single-line clean-plus-invalidate, or a range clean or range invalidate with an inclusive first-line and last-line address.

Invalidate requests must not discard data in lines they only partly cover. Such edge lines get a single-line clean-plus-invalidate, and only the fully covered lines are range-invalidated. Clean and flush requests widen the range to whole lines instead. The aligned middle is cut into chunks. A chunk never exceeds a byte cap and never crosses a page. Each command is held on the command port until the engine pulses completion, and a one-cycle done pulse closes the request. A write-through input tells the block that the cache holds no dirty data, so all clean work is dropped.

Top module: `maint_range_splitter`

## Requirements
- R1: After reset, and after any reset in the middle of a request, `req_ready` is 1, `cmd_valid` is 0 and `req_done` is 0.
- R2: A range command (kind 1 = range clean, kind 2 = range invalidate) has `cmd_lo` equal to the chunk start and `cmd_hi` equal to the chunk's exclusive end minus one line (32 bytes), so `cmd_hi` is the address of the last line in the chunk.
- R3: No chunk spans more than 1024 bytes, so `cmd_hi - cmd_lo` is at most 992.
- R4: No chunk crosses a 4096-byte page. When a chunk would cross, it ends at the start of the next page.
- R5: For an invalidate request (op 0) with a start that is not line aligned, the first command is kind 0 (single-line clean-plus-invalidate, `cmd_lo` = `cmd_hi` = line address) on the line that holds the start. The working start then becomes the next line boundary.
- R6: For an invalidate request, the line holding the end gets a kind 0 command, and the end is rounded down to a line boundary, but only if the end is not line aligned and the working start from R5 is still below the end. This command comes after any R5 command and before all range commands.
- R7: For clean (op 1) and flush (op 2), the start is rounded down and the end is rounded up to 32-byte boundaries before chunking. Every emitted address is line aligned.
- R8: For flush without write-through, each chunk gives a range clean and then a range invalidate over the same `cmd_lo`/`cmd_hi`. Chunks are issued in rising address order.
- R9: When `wt_mode` is 1 at acceptance, a clean request emits no command. A flush request then emits only the range invalidate for each chunk.
- R10: At most one command is outstanding. Its kind, `cmd_lo` and `cmd_hi` stay stable while `cmd_valid` is high until `cmd_done` is seen. The next command appears only after that.
- R11: A request whose working start is not below its working end (for example, an invalidate with start equal to end) emits no command but still gives the done pulse.
- R12: Each accepted request gives exactly one `req_done` pulse, one cycle wide, after its last command has completed. `cmd_valid` is low while `req_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present; taken when `req_ready` is 1 |
| req_ready | output | 1 | Block is idle and can take a request |
| req_op | input | 2 | 0 invalidate, 1 clean, 2 flush |
| req_start | input | ADDR_W | First byte address of the request |
| req_end | input | ADDR_W | Byte address one past the last byte |
| wt_mode | input | 1 | Write-through mode, sampled when a request is accepted |
| cmd_valid | output | 1 | Engine command present |
| cmd_kind | output | 2 | 0 line clean+invalidate, 1 range clean, 2 range invalidate |
| cmd_lo | output | ADDR_W | First line address of the command |
| cmd_hi | output | ADDR_W | Last line address of the command (inclusive) |
| cmd_done | input | 1 | One-cycle completion of the current command |
| req_done | output | 1 | One-cycle pulse when the request has finished |

## Verification
The assertions assume that the engine pulses `cmd_done` for a single cycle and only while `cmd_valid` is high. They also assume that requests use one of the three defined operation codes and that the rounded-up end does not wrap past the top of the address space. The bench responder follows these rules: it raises `cmd_done` only after it has seen a command and drops it on the next cycle, and it can be told to wait extra cycles so that holding of the command is exercised. All request addresses stay far below the top of the address space, and only codes 0 to 2 are driven.

// File: rtl/msp_pkg.sv
// Shared encodings for the maintenance range splitter.
// Assumes: requesters drive only the three defined operation codes.
package msp_pkg;
    typedef enum logic [1:0] {
        OP_INV   = 2'd0,
        OP_CLEAN = 2'd1,
        OP_FLUSH = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        CMD_LINE_CI     = 2'd0,
        CMD_RANGE_CLEAN = 2'd1,
        CMD_RANGE_INV   = 2'd2
    } cmd_e;
endpackage

// File: rtl/msp_chunk_calc.sv
// Computes the exclusive end of the next chunk starting at the working
// start: the smallest of the working end, start plus the byte cap, and the
// next page boundary. Also gives the inclusive last-line address.
// Assumes: cur and fin are line aligned and cur < fin when the result is used.
module msp_chunk_calc #(
    parameter int ADDR_W      = 32,
    parameter int LINE_BYTES  = 32,
    parameter int CHUNK_BYTES = 1024,
    parameter int PAGE_BYTES  = 4096
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic [ADDR_W-1:0] fin,
    output logic [ADDR_W-1:0] chunk_end,
    output logic [ADDR_W-1:0] chunk_hi
);
    localparam logic [ADDR_W-1:0] LINE_V    = ADDR_W'(LINE_BYTES);
    localparam logic [ADDR_W-1:0] CHUNK_V   = ADDR_W'(CHUNK_BYTES);
    localparam logic [ADDR_W-1:0] PAGE_MASK = ADDR_W'(PAGE_BYTES - 1);

    logic [ADDR_W-1:0] cap_end;
    logic [ADDR_W-1:0] page_end;

    // Clip the chunk to the byte cap and then to the page boundary.
    always_comb begin
        cap_end   = cur + CHUNK_V;
        page_end  = (cur | PAGE_MASK) + 1'b1;
        chunk_end = fin;
        if (chunk_end > cap_end)  chunk_end = cap_end;
        if (chunk_end > page_end) chunk_end = page_end;
        chunk_hi  = chunk_end - LINE_V;
    end
endmodule

// File: rtl/msp_seq.sv
// Request sequencer: accepts a request, derives the working start and end
// for the operation, issues edge-line commands and then chunk commands one
// at a time, and pulses done once nothing is left.
// Assumes: cmd_done is a single-cycle pulse given only while cmd_valid is high.
module msp_seq
    import msp_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_start,
    input  logic [ADDR_W-1:0] req_end,
    input  logic              wt_mode,
    input  logic [ADDR_W-1:0] chunk_end,
    input  logic [ADDR_W-1:0] chunk_hi,
    output logic [ADDR_W-1:0] cur,
    output logic [ADDR_W-1:0] fin,
    output logic              cmd_valid,
    output logic [1:0]        cmd_kind,
    output logic [ADDR_W-1:0] cmd_lo,
    output logic [ADDR_W-1:0] cmd_hi,
    input  logic              cmd_done,
    output logic              req_done
);
    localparam logic [ADDR_W-1:0] LINE_V = ADDR_W'(LINE_BYTES);
    localparam logic [ADDR_W-1:0] LMASK  = LINE_V - 1'b1;

    logic              busy, head_pend, tail_pend, inv_phase, done_q, wt_q;
    op_e               op_q;
    logic [ADDR_W-1:0] cur_q, fin_q;

    logic [ADDR_W-1:0] start_dn, start_up, end_dn, end_up;
    logic [ADDR_W-1:0] acc_cur, acc_fin;
    logic              acc_head, acc_tail;
    op_e               req_op_e;

    logic              has_work;
    cmd_e              sel_kind;
    logic [ADDR_W-1:0] sel_lo, sel_hi;

    // Derive the working range and edge-line flags for an incoming request.
    always_comb begin
        req_op_e = op_e'(req_op);
        start_dn = req_start & ~LMASK;
        start_up = (req_start + LMASK) & ~LMASK;
        end_dn   = req_end & ~LMASK;
        end_up   = (req_end + LMASK) & ~LMASK;
        acc_head = 1'b0;
        acc_tail = 1'b0;
        if (req_op_e == OP_INV) begin
            // Head line address is recovered later as acc_cur minus one line.
            acc_head = |(req_start & LMASK);
            acc_tail = (start_up < req_end) && |(req_end & LMASK);
            acc_cur  = start_up;
            acc_fin  = end_dn;
        end else begin
            acc_cur  = start_dn;
            acc_fin  = (req_op_e == OP_CLEAN && wt_mode) ? start_dn : end_up;
        end
    end

    // Pick the command owed next: head line, tail line, then chunks.
    always_comb begin
        has_work = 1'b0;
        sel_kind = CMD_LINE_CI;
        sel_lo   = '0;
        sel_hi   = '0;
        if (head_pend) begin
            has_work = 1'b1;
            sel_lo   = cur_q - LINE_V;
            sel_hi   = cur_q - LINE_V;
        end else if (tail_pend) begin
            has_work = 1'b1;
            sel_lo   = fin_q;
            sel_hi   = fin_q;
        end else if (cur_q < fin_q) begin
            has_work = 1'b1;
            sel_lo   = cur_q;
            sel_hi   = chunk_hi;
            if (op_q == OP_INV)        sel_kind = CMD_RANGE_INV;
            else if (op_q == OP_CLEAN) sel_kind = CMD_RANGE_CLEAN;
            else                       sel_kind = (wt_q || inv_phase) ? CMD_RANGE_INV
                                                                      : CMD_RANGE_CLEAN;
        end
    end

    // Request state: accept, advance on each completion, finish with a pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            head_pend <= 1'b0;
            tail_pend <= 1'b0;
            inv_phase <= 1'b0;
            done_q    <= 1'b0;
            wt_q      <= 1'b0;
            op_q      <= OP_INV;
            cur_q     <= '0;
            fin_q     <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy) begin
                if (req_valid) begin
                    busy      <= 1'b1;
                    op_q      <= req_op_e;
                    wt_q      <= wt_mode;
                    inv_phase <= 1'b0;
                    head_pend <= acc_head;
                    tail_pend <= acc_tail;
                    cur_q     <= acc_cur;
                    fin_q     <= acc_fin;
                end
            end else if (!has_work) begin
                busy   <= 1'b0;
                done_q <= 1'b1;
            end else if (cmd_done) begin
                if (head_pend) begin
                    head_pend <= 1'b0;
                end else if (tail_pend) begin
                    tail_pend <= 1'b0;
                end else if (op_q == OP_FLUSH && !wt_q && !inv_phase) begin
                    inv_phase <= 1'b1;
                end else begin
                    inv_phase <= 1'b0;
                    cur_q     <= chunk_end;
                end
            end
        end
    end

    assign req_ready = !busy;
    assign cmd_valid = busy && has_work;
    assign cmd_kind  = sel_kind;
    assign cmd_lo    = sel_lo;
    assign cmd_hi    = sel_hi;
    assign req_done  = done_q;
    assign cur       = cur_q;
    assign fin       = fin_q;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !cmd_valid); // R1
    AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_done) |=> (cmd_valid && $stable(cmd_kind)
                                      && $stable(cmd_lo) && $stable(cmd_hi))); // R10
    AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ((cmd_lo & LMASK) == '0 && (cmd_hi & LMASK) == '0)); // R7
    AST_DONE_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |-> !cmd_valid); // R12
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |=> !req_done); // R12
endmodule

// File: rtl/maint_range_splitter.sv
// Top of the maintenance range splitter: joins the request sequencer with
// the chunk boundary calculator and checks the shape of emitted ranges.
// Assumes: addresses do not wrap past the top of the address space.
module maint_range_splitter #(
    parameter int ADDR_W      = 32,
    parameter int LINE_BYTES  = 32,
    parameter int CHUNK_BYTES = 1024,
    parameter int PAGE_BYTES  = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_start,
    input  logic [ADDR_W-1:0] req_end,
    input  logic              wt_mode,
    output logic              cmd_valid,
    output logic [1:0]        cmd_kind,
    output logic [ADDR_W-1:0] cmd_lo,
    output logic [ADDR_W-1:0] cmd_hi,
    input  logic              cmd_done,
    output logic              req_done
);
    localparam logic [ADDR_W-1:0] SPAN_MAX  = ADDR_W'(CHUNK_BYTES - LINE_BYTES);
    localparam logic [ADDR_W-1:0] PAGE_MASK = ADDR_W'(PAGE_BYTES - 1);

    logic [ADDR_W-1:0] cur, fin, chunk_end, chunk_hi;

    msp_chunk_calc #(
        .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES),
        .CHUNK_BYTES(CHUNK_BYTES), .PAGE_BYTES(PAGE_BYTES)
    ) u_chunk (
        .cur(cur), .fin(fin), .chunk_end(chunk_end), .chunk_hi(chunk_hi)
    );

    msp_seq #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_start(req_start), .req_end(req_end), .wt_mode(wt_mode),
        .chunk_end(chunk_end), .chunk_hi(chunk_hi), .cur(cur), .fin(fin),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_lo(cmd_lo),
        .cmd_hi(cmd_hi), .cmd_done(cmd_done), .req_done(req_done)
    );

    AST_RANGE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind != 2'd0) |-> (cmd_hi >= cmd_lo)); // R2
    AST_CHUNK_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ((cmd_hi - cmd_lo) <= SPAN_MAX)); // R3
    AST_SAME_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ((cmd_lo & ~PAGE_MASK) == (cmd_hi & ~PAGE_MASK))); // R4
endmodule

// File: tb/maint_range_splitter_bench.sv
`timescale 1ns/1ps
module maint_range_splitter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic [31:0] req_start = '0, req_end = '0;
    logic        wt_mode = 1'b0;
    logic        cmd_valid;
    logic [1:0]  cmd_kind;
    logic [31:0] cmd_lo, cmd_hi;
    logic        cmd_done = 1'b0;
    logic        req_done;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    maint_range_splitter u_maint_range_splitter (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_start(req_start), .req_end(req_end),
        .wt_mode(wt_mode), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_lo(cmd_lo), .cmd_hi(cmd_hi), .cmd_done(cmd_done),
        .req_done(req_done)
    );

    // Stimulus table: {op, wt, start, end}
    localparam int NVEC = 10;
    localparam logic [66:0] VEC [NVEC] = '{
        {2'd0, 1'b0, 32'h0000_1000, 32'h0000_1100},
        {2'd0, 1'b0, 32'h0000_1005, 32'h0000_1047},
        {2'd0, 1'b0, 32'h0000_2004, 32'h0000_2010},
        {2'd1, 1'b0, 32'h0000_3010, 32'h0000_3850},
        {2'd2, 1'b0, 32'h0000_4F00, 32'h0000_5100},
        {2'd1, 1'b1, 32'h0000_3010, 32'h0000_3850},
        {2'd2, 1'b1, 32'h0000_6000, 32'h0000_6040},
        {2'd0, 1'b0, 32'h0000_7000, 32'h0000_7000},
        {2'd1, 1'b0, 32'h0000_8000, 32'h0000_8001},
        {2'd0, 1'b0, 32'h0000_9010, 32'h0000_9080}
    };

    function automatic string tag_of(int i);
        case (i)
            0: return "R2";
            1: return "R5 R6";
            2: return "R5";
            3: return "R3 R7";
            4: return "R4 R8";
            5: return "R9";
            6: return "R9";
            7: return "R11";
            8: return "R7";
            default: return "R5";
        endcase
    endfunction

    // Expected and observed command logs.
    logic [1:0]  exp_k [64];
    logic [31:0] exp_lo [64], exp_hi [64];
    int          exp_n;
    logic [1:0]  act_k [64];
    logic [31:0] act_lo [64], act_hi [64];
    int          act_n = 0;
    int          done_cnt = 0;
    int          resp_delay = 0;
    int          hold = 0;
    int          unstable = 0;
    logic [1:0]  snap_k;
    logic [31:0] snap_lo, snap_hi;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [65:0] act, input logic [65:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [1:0] k, input logic [31:0] lo, input logic [31:0] hi);
        exp_k[exp_n] = k; exp_lo[exp_n] = lo; exp_hi[exp_n] = hi; exp_n++;
    endtask

    function automatic logic [31:0] chunk_stop(input logic [31:0] s, input logic [31:0] e);
        logic [31:0] r = e;
        if (r > s + 32'd1024) r = s + 32'd1024;
        if (r > ((s | 32'hFFF) + 32'd1)) r = (s | 32'hFFF) + 32'd1;
        return r;
    endfunction

    // Model of the requirements (R2..R9, R11): fill the expected log.
    task automatic build_expected(input logic [1:0] op, input logic wt,
                                  input logic [31:0] s0, input logic [31:0] e0);
        logic [31:0] s = s0, e = e0, r;
        exp_n = 0;
        if (op == 2'd0) begin
            if (s[4:0] != 0) begin push(2'd0, s & ~32'h1F, s & ~32'h1F); s = (s | 32'h1F) + 1; end
            if (s < e && e[4:0] != 0) begin push(2'd0, e & ~32'h1F, e & ~32'h1F); e = e & ~32'h1F; end
            while (s < e) begin
                r = chunk_stop(s, e); push(2'd2, s, r - 32'd32); s = r;
            end
        end else begin
            s = s & ~32'h1F;
            e = (e + 32'h1F) & ~32'h1F;
            if (!(op == 2'd1 && wt)) begin
                while (s != e) begin
                    r = chunk_stop(s, e);
                    if (!wt) push(2'd1, s, r - 32'd32);
                    if (op == 2'd2) push(2'd2, s, r - 32'd32);
                    s = r;
                end
            end
        end
    endtask

    // Engine model: logs each command once, holds it for resp_delay cycles,
    // then pulses cmd_done for one cycle (R10).
    always @(negedge clk) begin
        if (!rst_n) begin
            cmd_done = 1'b0; hold = 0;
        end else begin
            if (req_done) done_cnt++;
            if (cmd_done) begin
                cmd_done = 1'b0;
            end else if (cmd_valid) begin
                if (hold == 0) begin
                    if (act_n < 64) begin
                        act_k[act_n] = cmd_kind; act_lo[act_n] = cmd_lo; act_hi[act_n] = cmd_hi;
                    end
                    act_n++;
                    snap_k = cmd_kind; snap_lo = cmd_lo; snap_hi = cmd_hi;
                end else if (cmd_kind != snap_k || cmd_lo != snap_lo || cmd_hi != snap_hi) begin
                    unstable++;
                end
                if (hold >= resp_delay) begin cmd_done = 1'b1; hold = 0; end
                else hold++;
            end
        end
    end

    task automatic run_req(input logic [1:0] op, input logic wt, input logic [31:0] s,
                           input logic [31:0] e, input string tag);
        build_expected(op, wt, s, e);
        act_n = 0; done_cnt = 0;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; wt_mode = wt; req_start = s; req_end = e;
        @(negedge clk);
        req_valid = 1'b0;
        for (int t = 0; t < 5000 && done_cnt == 0; t++) @(negedge clk);
        repeat (4) @(negedge clk);
        check(act_n == exp_n, tag, "command count", 66'(act_n), 66'(exp_n));
        begin
            bit ok = 1'b1;
            logic [65:0] a = '0, x = '0;
            for (int i = 0; i < exp_n && i < act_n; i++) begin
                if (ok && {act_k[i], act_lo[i], act_hi[i]} != {exp_k[i], exp_lo[i], exp_hi[i]}) begin
                    ok = 1'b0;
                    a = {act_k[i], act_lo[i], act_hi[i]};
                    x = {exp_k[i], exp_lo[i], exp_hi[i]};
                end
            end
            check(ok, tag, "command {kind,lo,hi}", a, x);
        end
        check(done_cnt == 1, "R12", "done pulses", 66'(done_cnt), 66'd1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: idle outputs under reset and right after release.
        check(req_ready == 1'b1 && cmd_valid == 1'b0 && req_done == 1'b0, "R1",
              "reset outputs {ready,valid,done}", {63'd0, req_ready, cmd_valid, req_done}, 66'b100);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && cmd_valid == 1'b0, "R1", "idle after release",
              {64'd0, req_ready, cmd_valid}, 66'b10);

        for (int v = 0; v < NVEC; v++)
            run_req(VEC[v][66:65], VEC[v][64], VEC[v][63:32], VEC[v][31:0], tag_of(v));

        // R10: slow engine, commands must hold and not advance early.
        resp_delay = 3; unstable = 0;
        run_req(2'd2, 1'b0, 32'h0000_4F00, 32'h0000_5100, "R10 R8");
        check(unstable == 0, "R10", "command changed while waiting", 66'(unstable), 66'd0);
        resp_delay = 0;

        // R11: invalidate inside one line, start rounded past end, no tail.
        run_req(2'd0, 1'b0, 32'h0000_A001, 32'h0000_A002, "R11 R6");

        // R1: reset in the middle of a long clean.
        build_expected(2'd1, 1'b0, 32'h0000_3010, 32'h0000_3850);
        act_n = 0;
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd1; wt_mode = 1'b0;
        req_start = 32'h0000_3010; req_end = 32'h0000_3850;
        @(negedge clk);
        req_valid = 1'b0;
        for (int t = 0; t < 100 && act_n < 2; t++) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1 && cmd_valid == 1'b0 && req_done == 1'b0, "R1",
              "mid-request reset outputs", {63'd0, req_ready, cmd_valid, req_done}, 66'b100);
        rst_n = 1'b1;
        @(negedge clk);
        check(cmd_valid == 1'b0, "R1", "no command after reset", 66'(cmd_valid), 66'd0);

        // Service still works after the interrupted request.
        run_req(2'd0, 1'b0, 32'h0000_1005, 32'h0000_1047, "R5 R6");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule